// File: doc/BRIEF.md
# Ethernet Frame Transmitter with Automatic FCS

This block is the transmit side of a simple byte-oriented Ethernet adapter. Software places the frame payload into a transmit buffer. That buffer shares one address window with the receive side: a processor write that lands in the window is stored in the transmit buffer. A processor read in the same window is handed to the external receive buffer, and its data comes back on the next cycle. Two byte registers hold the data length, and a control register starts a send when software writes the value 0x01 to it.

Once started, the engine reads the stored bytes in order and presents them one at a time on a valid/ready byte stream toward the MAC/PHY. It computes the Ethernet CRC-32 as the bytes pass, then appends the four-byte frame check sequence by itself. After the last check byte is accepted, it raises a one-cycle completion event. Bit 0 of the control register reads back as a busy flag while a send is running.

Top module: `eth_tx_engine`

## Requirements
- R1: A processor write with `cpu_addr[11]` = 1 stores `cpu_wdata` at buffer offset `cpu_addr[10:0]` and never raises `rx_rd_en`.
- R2: A processor read with `cpu_addr[11]` = 1 (and no write) raises `rx_rd_en` in the same cycle with `rx_rd_addr` = `cpu_addr[10:0]`. One cycle later `cpu_rdata` equals `rx_rd_data`.
- R3: The data length is a 16-bit value held little-endian: low byte at address 0x003, high byte at 0x004. Both registers read back one cycle after a read.
- R4: A write of exactly 0x01 to address 0x005 starts a send. Any other value written there starts nothing.
- R5: A send emits exactly `length` data bytes, taken from buffer offsets 0, 1, 2 and so on in order, followed by exactly four check bytes.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold unchanged on the next cycle. A byte counts as transferred only in a cycle where both are high.
- R7: The check value is the CRC-32 (reflected polynomial 0xEDB88320, start value 0xFFFFFFFF) over the data bytes, inverted and sent least-significant byte first. For the nine ASCII bytes "123456789" the check bytes are 0x26, 0x39, 0xF4, 0xCB.
- R8: A length of zero sends only the four check bytes 0x00, 0x00, 0x00, 0x00.
- R9: `tx_done` is high for exactly the one cycle after the last check byte is transferred, and `tx_valid` is low in that cycle.
- R10: Bit 0 of address 0x005 reads 1 from the start of a send until its completion and 0 otherwise. A start write made while busy is ignored and produces no extra bytes.
- R11: After reset `tx_valid`, `tx_done` and the busy bit are 0, and both length registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 12 | Processor byte address |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_re | input | 1 | Processor read strobe |
| cpu_rdata | output | 8 | Processor read data, valid one cycle after `cpu_re` |
| rx_rd_en | output | 1 | Read request toward the receive buffer |
| rx_rd_addr | output | 11 | Offset of the receive buffer read |
| rx_rd_data | input | 8 | Receive buffer data, one cycle after `rx_rd_en` |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_done | output | 1 | One-cycle send-complete event |

## Verification
The hardest case to create from the ports is a start write that arrives mid-frame while the stream is stalled by back-pressure. The bench gets there by driving `tx_ready` from a pseudo-random pattern on a long frame. It reads the busy bit and issues a second 0x01 write while bytes are still queued. The reference model holds the expected bytes in a queue, so any stray repeated frame shows up as an unexpected transfer. Known-answer CRC bytes, a zero-length frame and a length above 255 cover the check-value and length-byte boundaries.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam int REG_LEN_LO = 3;
  localparam int REG_LEN_HI = 4;
  localparam int REG_CTRL   = 5;
  localparam logic [7:0] GO_CODE = 8'h01;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int FCS_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_LOAD,
    ST_SEND,
    ST_FCS
  } tx_st_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_tx_regs.sv
module eth_tx_regs
  import eth_tx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUF_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_re,
  output logic [7:0]        cpu_rdata,
  input  logic              busy,
  output logic              rx_rd_en,
  output logic [BUF_AW-1:0] rx_rd_addr,
  input  logic [7:0]        rx_rd_data,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic [15:0]       frame_len,
  output logic              start
);

  logic in_win;
  logic [7:0] len_lo_q, len_hi_q;
  logic [7:0] rd_reg_q;
  logic rd_win_q;

  assign in_win     = cpu_addr[ADDR_W-1];
  assign buf_we     = cpu_we & in_win;
  assign buf_waddr  = cpu_addr[BUF_AW-1:0];
  assign buf_wdata  = cpu_wdata;
  assign rx_rd_en   = cpu_re & in_win & ~cpu_we;
  assign rx_rd_addr = cpu_addr[BUF_AW-1:0];
  assign frame_len  = {len_hi_q, len_lo_q};
  assign start      = cpu_we && (cpu_addr == ADDR_W'(REG_CTRL)) && (cpu_wdata == GO_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_lo_q <= '0;
      len_hi_q <= '0;
    end else if (cpu_we && !in_win) begin
      if (cpu_addr == ADDR_W'(REG_LEN_LO)) len_lo_q <= cpu_wdata;
      if (cpu_addr == ADDR_W'(REG_LEN_HI)) len_hi_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg_q <= '0;
      rd_win_q <= 1'b0;
    end else begin
      rd_win_q <= rx_rd_en;
      if (cpu_re && !in_win) begin
        if (cpu_addr == ADDR_W'(REG_LEN_LO))      rd_reg_q <= len_lo_q;
        else if (cpu_addr == ADDR_W'(REG_LEN_HI)) rd_reg_q <= len_hi_q;
        else if (cpu_addr == ADDR_W'(REG_CTRL))   rd_reg_q <= {7'b0, busy};
        else                                      rd_reg_q <= '0;
      end
    end
  end

  assign cpu_rdata = rd_win_q ? rx_rd_data : rd_reg_q;

endmodule

// File: rtl/eth_tx_buf.sv
module eth_tx_buf #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/eth_tx_fsm.sv
module eth_tx_fsm
  import eth_tx_pkg::*;
#(
  parameter int BUF_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       frame_len,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [7:0]        buf_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_done,
  output logic              busy
);

  localparam int FIDX_W = $clog2(FCS_BYTES) + 1;

  tx_st_e st_q;
  logic [15:0] len_q, cnt_q;
  logic [31:0] crc_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [31:0] fcs_w;
  logic [7:0] fcs_byte;

  assign buf_raddr = cnt_q[BUF_AW-1:0];
  assign busy      = (st_q != ST_IDLE);
  assign fcs_w     = ~crc_q;
  assign fcs_byte  = fcs_w[{fidx_q[1:0], 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      len_q    <= '0;
      cnt_q    <= '0;
      crc_q    <= CRC_SEED;
      fidx_q   <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            len_q <= frame_len;
            cnt_q <= '0;
            crc_q <= CRC_SEED;
            if (frame_len == 16'd0) begin
              tx_data  <= ~CRC_SEED[7:0];
              tx_valid <= 1'b1;
              fidx_q   <= FIDX_W'(1);
              st_q     <= ST_FCS;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        ST_RD: st_q <= ST_LOAD;
        ST_LOAD: begin
          tx_data  <= buf_rdata;
          tx_valid <= 1'b1;
          crc_q    <= crc32_step(crc_q, buf_rdata);
          cnt_q    <= cnt_q + 16'd1;
          st_q     <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (cnt_q == len_q) begin
              tx_data <= fcs_w[7:0];
              fidx_q  <= FIDX_W'(1);
              st_q    <= ST_FCS;
            end else begin
              tx_valid <= 1'b0;
              st_q     <= ST_RD;
            end
          end
        end
        ST_FCS: begin
          if (tx_ready) begin
            if (fidx_q == FIDX_W'(FCS_BYTES)) begin
              tx_valid <= 1'b0;
              tx_done  <= 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              tx_data <= fcs_byte;
              fidx_q  <= fidx_q + FIDX_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eth_tx_engine.sv
module eth_tx_engine #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_re,
  output logic [7:0]        cpu_rdata,
  output logic              rx_rd_en,
  output logic [ADDR_W-2:0] rx_rd_addr,
  input  logic [7:0]        rx_rd_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_done
);

  localparam int BUF_AW = ADDR_W - 1;

  logic              busy;
  logic              start;
  logic [15:0]       frame_len;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [7:0]        buf_wdata, buf_rdata;

  eth_tx_regs #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) regs_i (
    .clk(clk), .rst(rst),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .busy(busy),
    .rx_rd_en(rx_rd_en), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .frame_len(frame_len), .start(start)
  );

  eth_tx_buf #(.AW(BUF_AW)) buf_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  eth_tx_fsm #(.BUF_AW(BUF_AW)) fsm_i (
    .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_done(tx_done), .busy(busy)
  );

endmodule

// File: rtl/eth_tx_chk.sv
module eth_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_we,
  input logic       rx_rd_en,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_done,
  input logic       busy
);

  p_hold_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid);

  p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_valid && !busy));

  p_win_write_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_we |-> !rx_rd_en);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);

endmodule

bind eth_tx_engine eth_tx_chk chk_i (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .rx_rd_en(rx_rd_en),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_done(tx_done), .busy(busy)
);

// File: tb/eth_tx_engine_tb.sv
module eth_tx_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_re = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        rx_rd_en;
  logic [10:0] rx_rd_addr;
  logic [7:0]  rx_rd_data = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        tx_done;

  always #4 clk = ~clk;

  eth_tx_engine dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .rx_rd_en(rx_rd_en), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done)
  );

  always @(posedge clk) if (rx_rd_en) rx_rd_data <= rx_rd_addr[7:0] ^ 8'hA5;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int frames_done = 0;
  int cyc = 0;
  bit rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit last_pend = 0, prev_stall = 0;
  logic [7:0] prev_data = '0;
  logic [31:0] crc_acc;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c = c_in;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
    if (last_pend || tx_done) chk("R9 done", tx_done, last_pend);
    if (last_pend) chk("R9 valid low", tx_valid, 0);
    if (tx_done) frames_done++;
    if (prev_stall) begin
      chk("R6 hold valid", tx_valid, 1);
      chk("R6 hold data", tx_data, prev_data);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    last_pend = 0;
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected byte", 1, 0);
      end else begin
        chk("R5 R7 byte", tx_data, exp_q.pop_front());
        last_pend = (exp_q.size() == 0);
      end
    end
    prev_stall = tx_valid && !tx_ready;
    prev_data = tx_data;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_addr = 12'(a); cpu_wdata = 8'(d); cpu_we = 1'b1;
    #1;
    if (a >= 12'h800) chk("R1 no rx read on write", rx_rd_en, 0);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    cpu_addr = 12'(a); cpu_re = 1'b1;
    #1;
    if (a >= 12'h800) begin
      chk("R2 rx_rd_en", rx_rd_en, 1);
      chk("R2 rx_rd_addr", rx_rd_addr, a & 12'h7FF);
    end
    @(negedge clk);
    cpu_re = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic load_frame(input int len, input int seed, input bit ascii);
    crc_acc = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      int b;
      b = ascii ? (8'h31 + i) : ((i * 37 + seed) & 8'hFF);
      wr(12'h800 + i, b);
      exp_q.push_back(b);
      crc_acc = ref_crc_byte(crc_acc, 8'(b));
    end
    crc_acc = ~crc_acc;
    for (int k = 0; k < 4; k++) exp_q.push_back((crc_acc >> (8 * k)) & 8'hFF);
    wr(3, len & 8'hFF);
    wr(4, (len >> 8) & 8'hFF);
  endtask

  task automatic wait_frame(input int n0);
    while (frames_done == n0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R5 queue drained", exp_q.size(), 0);
    chk("R10 idle after frame", tx_valid, 0);
  endtask

  initial begin
    int d;
    int n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 tx_valid", tx_valid, 0);
    chk("R11 tx_done", tx_done, 0);
    rd(3, d); chk("R11 len lo", d, 0);
    rd(4, d); chk("R11 len hi", d, 0);
    rd(5, d); chk("R11 busy", d, 0);

    rd(12'h812, d); chk("R2 rx data", d, 8'h12 ^ 8'hA5);
    rd(12'hFFF, d); chk("R2 rx data top", d, 8'hFF ^ 8'hA5);

    load_frame(9, 0, 1);
    chk("R7 known fcs", crc_acc, 32'hCBF43926);
    rd(3, d); chk("R3 len lo", d, 9);
    rd(4, d); chk("R3 len hi", d, 0);
    wr(5, 8'h02);
    repeat (10) @(negedge clk);
    chk("R4 non-01 ignored valid", tx_valid, 0);
    rd(5, d); chk("R4 non-01 ignored busy", d, 0);
    n0 = frames_done;
    wr(5, 8'h01);
    wait_frame(n0);
    rd(5, d); chk("R10 busy clear", d, 0);

    rdy_rand = 1;
    load_frame(40, 7, 0);
    n0 = frames_done;
    wr(5, 8'h01);
    rd(5, d); chk("R10 busy set", d, 1);
    repeat (15) @(negedge clk);
    wr(5, 8'h01);
    wait_frame(n0);

    exp_q.push_back(0); exp_q.push_back(0); exp_q.push_back(0); exp_q.push_back(0);
    wr(3, 0); wr(4, 0);
    n0 = frames_done;
    wr(5, 8'h01);
    wait_frame(n0);
    chk("R8 zero length done", frames_done, n0 + 1);

    load_frame(300, 3, 0);
    rd(3, d); chk("R3 len lo 300", d, 8'h2C);
    rd(4, d); chk("R3 len hi 300", d, 8'h01);
    n0 = frames_done;
    wr(5, 8'h01);
    wait_frame(n0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule